// File: doc/BRIEF.md
# External Pin Edge Interrupt Qualifier

This block watches one asynchronous interrupt pin on behalf of a small microcontroller core. The pin is synchronised and then filtered, so a new level counts only once it has been held for a minimum number of system clocks. A change of the filtered level is an edge. A 4-bit control register selects which edges are valid: falling only, rising only, or both. The same register holds a pin enable and a timer-start synchronisation select. A valid edge sets a sticky request flag.

The core reads the flag in two ways. It can poll the flag as a skip-test result, and then it pulses a "skip taken" strobe to clear the flag. Or the flag raises an interrupt request when both the source enable and the global enable are high. In that case the core pulses an acknowledge to clear the flag. A level-test output reports whether the filtered pin sits at the level that the polarity bit selects. A one-cycle timer-start pulse can go with each valid edge. The control register is written from the accumulator and read back to it.

The block has no streaming data path. Every pin is a plain control or status signal, and none of them uses back-pressure.

Top module: `ext_edge_irq`

## Requirements
- R1: After reset the control register reads 0000, and the request flag, the interrupt request and the timer-start output are all 0.
- R2: A cycle with `ctrl_wr` high loads `acc_wr_data` into the control register, and the new value appears on `ctrl_rd_data` after that clock edge. Without a write, the register holds its value.
- R3: Control bit 3 enables the pin (1 = enabled). While it is 0, no pin edge sets the request flag.
- R4: When bit 1 = 0, bit 2 selects one edge: 0 = falling edges only, 1 = rising edges only. The other edge has no effect on the flag.
- R5: When bit 1 = 1, both rising and falling edges set the flag, whatever the value of bit 2.
- R6: A new pin level is qualified only when the synchronised level stays unchanged for MIN_HOLD (default 4) consecutive clocks. A shorter pulse produces no edge.
- R7: The request flag stays set until `irq_ack` or `skip_taken` is high for a cycle, and that cycle clears it.
- R8: When a valid edge and a clear arrive in the same cycle, the flag ends that cycle set.
- R9: `irq_req` is high exactly when the flag, `src_en` and `glob_en` are all 1.
- R10: `level_test` is 1 when the filtered pin level equals control bit 2 (0 = low, 1 = high), and 0 otherwise.
- R11: With control bit 0 = 1, each valid edge gives exactly one cycle of `tmr_start`, in the same cycle the flag rises. With bit 0 = 0, `tmr_start` stays 0.
- R12: With the default two synchroniser stages and MIN_HOLD = 4, the flag rises on the sixth rising clock edge after the one that first samples the pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| pin_in | input | 1 | Asynchronous external interrupt pin |
| ctrl_wr | input | 1 | Control register write strobe |
| acc_wr_data | input | 4 | Value written to the control register |
| ctrl_rd_data | output | 4 | Control register contents |
| src_en | input | 1 | Enable for this interrupt source |
| glob_en | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt accepted; clears the flag |
| skip_taken | input | 1 | Skip on the flag was performed; clears the flag |
| skip_flag | output | 1 | Current request flag (skip-test result) |
| level_test | output | 1 | Filtered pin is at the selected level |
| irq_req | output | 1 | Gated interrupt request |
| tmr_start | output | 1 | One-cycle timer-start pulse |

## Verification
The bound checker runs on every cycle. It checks that the control register loads only on a write and holds otherwise. It checks the flag's response to a valid edge, to a clear and to both at once, and that the flag holds while neither clear strobe is present. It also checks that the interrupt request is gated by both enables, and that a timer-start pulse always comes with a set flag.

Other properties depend on the pin's history over many cycles, so only the bench scenarios can show them. These include the minimum-width filtering, the choice of edge for each polarity and each edge mode, the exact latency from pin to flag, and the level-test result.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int CTRL_W = 4;

  // Field order follows the register bit positions: pin_en is bit 3.
  typedef struct packed {
    logic pin_en;      // bit 3: accept pin edges
    logic rise_pol;    // bit 2: 1 = rising / high, 0 = falling / low
    logic both_edges;  // bit 1: 1 = both edges valid
    logic tmr_sync;    // bit 0: valid edge also starts the timer
  } eirq_ctrl_t;
endpackage

// File: rtl/eirq_sync_filter.sv
module eirq_sync_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HOLD    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  output logic level_o,
  output logic edge_o
);
  localparam int CNT_W = $clog2(MIN_HOLD + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(MIN_HOLD - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   s_lvl;
  logic                   cand_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   qual_q;
  logic                   edge_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin_raw;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
    end
  endgenerate

  assign s_lvl = sync_q[SYNC_STAGES-1];

  // The candidate level is counted from the first cycle it is seen; a
  // change restarts the count and the count saturates at HOLD_LAST.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= 1'b0;
      cnt_q  <= HOLD_LAST;
      qual_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      edge_q <= 1'b0;
      if (s_lvl != cand_q) begin
        cand_q <= s_lvl;
        cnt_q  <= CNT_W'(1);
      end else if (cnt_q == HOLD_LAST) begin
        if (cand_q != qual_q) begin
          qual_q <= cand_q;
          edge_q <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign level_o = qual_q;
  assign edge_o  = edge_q;
endmodule

// File: rtl/eirq_edge_sel.sv
module eirq_edge_sel
  import eirq_pkg::*;
(
  input  eirq_ctrl_t ctrl,
  input  logic       edge_i,
  input  logic       level_i,
  output logic       valid_o,
  output logic       at_level_o
);
  logic rise, fall, picked;

  assign rise   = edge_i & level_i;
  assign fall   = edge_i & ~level_i;
  assign picked = ctrl.both_edges ? (rise | fall)
                                  : (ctrl.rise_pol ? rise : fall);
  assign valid_o    = ctrl.pin_en & picked;
  assign at_level_o = (level_i == ctrl.rise_pol);
endmodule

// File: rtl/eirq_req_flag.sv
module eirq_req_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  input  logic skip_i,
  input  logic tsync_i,
  output logic flag_o,
  output logic tmr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      tmr_o  <= 1'b0;
    end else begin
      tmr_o <= set_i & tsync_i;
      if (set_i)               flag_o <= 1'b1;
      else if (ack_i | skip_i) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ext_edge_irq.sv
module ext_edge_irq
  import eirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HOLD    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_in,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] acc_wr_data,
  output logic [CTRL_W-1:0] ctrl_rd_data,
  input  logic              src_en,
  input  logic              glob_en,
  input  logic              irq_ack,
  input  logic              skip_taken,
  output logic              skip_flag,
  output logic              level_test,
  output logic              irq_req,
  output logic              tmr_start
);
  eirq_ctrl_t ctrl_q;
  logic       filt_lvl, filt_edge, edge_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= eirq_ctrl_t'(acc_wr_data);

  assign ctrl_rd_data = ctrl_q;

  eirq_sync_filter #(.SYNC_STAGES(SYNC_STAGES), .MIN_HOLD(MIN_HOLD)) u_filt (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_in),
    .level_o(filt_lvl), .edge_o(filt_edge)
  );

  eirq_edge_sel u_sel (
    .ctrl(ctrl_q), .edge_i(filt_edge), .level_i(filt_lvl),
    .valid_o(edge_ok), .at_level_o(level_test)
  );

  eirq_req_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(edge_ok), .ack_i(irq_ack),
    .skip_i(skip_taken), .tsync_i(ctrl_q.tmr_sync),
    .flag_o(skip_flag), .tmr_o(tmr_start)
  );

  assign irq_req = skip_flag & src_en & glob_en;
endmodule

module ext_edge_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_wr,
  input logic [3:0] acc_wr_data,
  input logic [3:0] ctrl_rd_data,
  input logic       edge_ok,
  input logic       irq_ack,
  input logic       skip_taken,
  input logic       skip_flag,
  input logic       src_en,
  input logic       glob_en,
  input logic       irq_req,
  input logic       tmr_start
);
  p_ctrl_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ctrl_rd_data == $past(acc_wr_data));
  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl_rd_data));
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_flag && !irq_ack && !skip_taken) |=> skip_flag);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_ack || skip_taken) && !edge_ok) |=> !skip_flag);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    edge_ok |=> skip_flag);
  p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en || !src_en || !skip_flag) |-> !irq_req);
  p_tmr_with_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_start |-> ($rose(skip_flag) || $past(edge_ok)));
endmodule

bind ext_edge_irq ext_edge_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .acc_wr_data(acc_wr_data),
  .ctrl_rd_data(ctrl_rd_data), .edge_ok(edge_ok), .irq_ack(irq_ack),
  .skip_taken(skip_taken), .skip_flag(skip_flag), .src_en(src_en),
  .glob_en(glob_en), .irq_req(irq_req), .tmr_start(tmr_start)
);

// File: tb/ext_edge_irq_bench.sv
`timescale 1ns/1ps
module ext_edge_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_in = 1'b0, ctrl_wr = 1'b0, src_en = 1'b0, glob_en = 1'b0;
  logic       irq_ack = 1'b0, skip_taken = 1'b0;
  logic [3:0] acc_wr_data = 4'h0;
  logic [3:0] ctrl_rd_data;
  logic       skip_flag, level_test, irq_req, tmr_start;
  int         n_tests = 0, n_fail = 0, tmr_cnt = 0;

  always #4 clk = ~clk;

  ext_edge_irq u_ext_edge_irq (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .ctrl_wr(ctrl_wr),
    .acc_wr_data(acc_wr_data), .ctrl_rd_data(ctrl_rd_data), .src_en(src_en),
    .glob_en(glob_en), .irq_ack(irq_ack), .skip_taken(skip_taken),
    .skip_flag(skip_flag), .level_test(level_test), .irq_req(irq_req),
    .tmr_start(tmr_start)
  );

  always @(posedge clk) if (tmr_start) tmr_cnt <= tmr_cnt + 1;

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [3:0] v);
    @(negedge clk); acc_wr_data = v; ctrl_wr = 1'b1;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic settle(); repeat (12) @(negedge clk); endtask

  task automatic do_skip();
    @(negedge clk); skip_taken = 1'b1;
    @(negedge clk); skip_taken = 1'b0;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk); pin_in = v; settle();
  endtask

  task automatic t_reset();
    chk("R1 ctrl", ctrl_rd_data, 4'h0);
    chk("R1 flag", {3'b0, skip_flag}, 4'h0);
    chk("R1 irq",  {3'b0, irq_req}, 4'h0);
    chk("R1 tmr",  {3'b0, tmr_start}, 4'h0);
  endtask

  task automatic t_regs();
    wr_ctrl(4'hA); chk("R2 write A", ctrl_rd_data, 4'hA);
    repeat (3) @(negedge clk); chk("R2 hold", ctrl_rd_data, 4'hA);
    wr_ctrl(4'h5); chk("R2 write 5", ctrl_rd_data, 4'h5);
  endtask

  task automatic t_enable();
    wr_ctrl(4'b0010);                // disabled, both edges
    set_pin(1'b1); set_pin(1'b0);
    chk("R3 disabled no flag", {3'b0, skip_flag}, 4'h0);
    wr_ctrl(4'b1010); settle();
    chk("R3 enable alone no flag", {3'b0, skip_flag}, 4'h0);
    set_pin(1'b1);
    chk("R3 enabled edge sets", {3'b0, skip_flag}, 4'h1);
    do_skip(); set_pin(1'b0); do_skip();
  endtask

  task automatic t_fall();
    wr_ctrl(4'b1000); do_skip();
    set_pin(1'b1); chk("R4 fall-mode rise ignored", {3'b0, skip_flag}, 4'h0);
    set_pin(1'b0); chk("R4 fall-mode fall sets", {3'b0, skip_flag}, 4'h1);
    do_skip();
  endtask

  task automatic t_rise_latency();
    wr_ctrl(4'b1100); do_skip();
    @(negedge clk); pin_in = 1'b1;
    repeat (6) @(posedge clk); @(negedge clk);
    chk("R12 not yet after 6 edges", {3'b0, skip_flag}, 4'h0);
    @(negedge clk);
    chk("R12 set on 7th edge from drive", {3'b0, skip_flag}, 4'h1);
    do_skip();
    set_pin(1'b0); chk("R4 rise-mode fall ignored", {3'b0, skip_flag}, 4'h0);
  endtask

  task automatic t_both();
    wr_ctrl(4'b1110); do_skip();
    set_pin(1'b1); chk("R5 both rise", {3'b0, skip_flag}, 4'h1);
    do_skip();
    set_pin(1'b0); chk("R5 both fall", {3'b0, skip_flag}, 4'h1);
    do_skip();
  endtask

  task automatic t_width();
    wr_ctrl(4'b1100); do_skip();
    @(negedge clk); pin_in = 1'b1;
    repeat (3) @(negedge clk); pin_in = 1'b0; settle();
    chk("R6 3-cycle pulse ignored", {3'b0, skip_flag}, 4'h0);
    @(negedge clk); pin_in = 1'b1;
    repeat (4) @(negedge clk); pin_in = 1'b0; settle();
    chk("R6 4-cycle pulse accepted", {3'b0, skip_flag}, 4'h1);
    do_skip();
  endtask

  task automatic t_clear();
    wr_ctrl(4'b1110); do_skip();
    set_pin(1'b1);
    repeat (5) @(negedge clk);
    chk("R7 sticky", {3'b0, skip_flag}, 4'h1);
    @(negedge clk); irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk("R7 ack clears", {3'b0, skip_flag}, 4'h0);
    set_pin(1'b0);
    do_skip();
    chk("R7 skip clears", {3'b0, skip_flag}, 4'h0);
  endtask

  task automatic t_set_wins();
    wr_ctrl(4'b1100);
    set_pin(1'b1); set_pin(1'b0);    // flag now set from the rise
    @(negedge clk); pin_in = 1'b1;
    repeat (6) @(posedge clk); @(negedge clk);
    skip_taken = 1'b1; @(negedge clk); skip_taken = 1'b0;
    chk("R8 set beats clear", {3'b0, skip_flag}, 4'h1);
    do_skip();
    chk("R8 later clear works", {3'b0, skip_flag}, 4'h0);
    set_pin(1'b0);
  endtask

  task automatic t_gate();
    wr_ctrl(4'b1000); do_skip();
    set_pin(1'b1); set_pin(1'b0);
    src_en = 1'b1; glob_en = 1'b0; @(negedge clk);
    chk("R9 glob off", {3'b0, irq_req}, 4'h0);
    src_en = 1'b0; glob_en = 1'b1; @(negedge clk);
    chk("R9 src off", {3'b0, irq_req}, 4'h0);
    src_en = 1'b1; @(negedge clk);
    chk("R9 all on", {3'b0, irq_req}, 4'h1);
    do_skip();
    chk("R9 flag clear", {3'b0, irq_req}, 4'h0);
    src_en = 1'b0; glob_en = 1'b0;
  endtask

  task automatic t_level();
    wr_ctrl(4'b1000); settle();
    chk("R10 low pol, pin low", {3'b0, level_test}, 4'h1);
    set_pin(1'b1);
    chk("R10 low pol, pin high", {3'b0, level_test}, 4'h0);
    wr_ctrl(4'b1100);
    chk("R10 high pol, pin high", {3'b0, level_test}, 4'h1);
    set_pin(1'b0); do_skip();
    chk("R10 high pol, pin low", {3'b0, level_test}, 4'h0);
  endtask

  task automatic t_tmr();
    wr_ctrl(4'b1110); do_skip();
    tmr_cnt = 0;
    set_pin(1'b1);
    chk("R11 no sync no pulse", 4'(tmr_cnt), 4'h0);
    wr_ctrl(4'b1111); do_skip();
    tmr_cnt = 0;
    set_pin(1'b0);
    chk("R11 one pulse per edge", 4'(tmr_cnt), 4'h1);
    do_skip();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_enable();
    t_fall();
    t_rise_latency();
    t_both();
    t_width();
    t_clear();
    t_set_wins();
    t_gate();
    t_level();
    t_tmr();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule